// File: doc/BRIEF.md
# Bus Burst Profile Monitor

This block sits beside the address-phase lines of an AHB-Lite master and watches them without driving anything. It checks that the master stays inside one bus-usage profile. Instruction fetches must be single transfers. Every data access must use the undefined-length incrementing burst type. None of the fixed-length incrementing or wrapping types may appear. Any beat after the first in a burst must be a word that follows the previous address by four bytes.

The monitor counts the accepted beats of every burst. A burst begins on a NONSEQ beat and ends at the next accepted IDLE or NONSEQ beat. The length cap is set at build time: 14 beats without a floating-point unit and 32 beats with one. The first violation sets a sticky flag and stores a cause code, and both hold until reset. At the end of each burst the monitor also reports a one-cycle completion strobe, the length of that burst and the longest burst seen so far.

Top module: `ahb_burst_checker`

## Requirements
- R1: While `rst` is high at a clock edge, and after it, every output is zero.
- R2: An accepted NONSEQ data beat (`hprot_data`=1) whose `hburst` is not INCR (1) sets error code 1 (bad type). An accepted SEQ beat whose `hburst` is not INCR, or differs from the first beat of its burst, also sets code 1.
- R3: An accepted NONSEQ instruction fetch (`hprot_data`=0) must have `hburst`=SINGLE (0). Any other value sets code 1.
- R4: An accepted beat with `hburst` from 2 to 7 (fixed-length types) sets code 2. This code takes precedence over code 1.
- R5: A single data access (one NONSEQ beat with INCR) of byte (0), halfword (1) or word (2) size is legal and completes as a burst of length 1.
- R6: An accepted SEQ beat whose `hsize` is not word (2), or whose burst began with a non-word beat, sets code 4.
- R7: An accepted SEQ beat that would make the burst longer than MAX_BEATS sets code 3. MAX_BEATS is 14 when HAS_FPU=0 and 32 when HAS_FPU=1.
- R8: An accepted SEQ beat with no burst in progress, or whose `haddr` is not the previous beat's address plus 4, sets code 5.
- R9: A beat is accepted only when `hready` is 1. `htrans` is coded IDLE=0, BUSY=1, NONSEQ=2, SEQ=3. BUSY neither counts nor ends a burst. An accepted IDLE or NONSEQ ends the current burst. In the next cycle `burst_done` is 1 for one cycle and `last_len` holds the burst's beat count.
- R10: `max_len` holds the largest completed burst length since reset. It saturates at 63.
- R11: `err_flag` and `err_code` are registered and sticky until reset. The code keeps the first error. Within one beat the priority is code 2, then 1, then 4, then 5, then 3.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst | input | 1 | Synchronous active-high reset |
| htrans | input | 2 | Transfer type of the address phase |
| hburst | input | 3 | Burst type of the address phase |
| hsize | input | 3 | Transfer size of the address phase |
| haddr | input | AW | Transfer address |
| hprot_data | input | 1 | Protection bit 0: 1 = data access, 0 = instruction fetch |
| hready | input | 1 | Transfer accepted / bus ready |
| err_flag | output | 1 | Sticky violation flag |
| err_code | output | 3 | Cause of the first violation (0 = none) |
| last_len | output | 6 | Beat count of the most recently completed burst |
| max_len | output | 6 | Longest completed burst since reset |
| burst_done | output | 1 | One-cycle strobe after a burst completes |

## Verification
The end of one burst and the start of the next can fall on the same accepted NONSEQ beat. That beat must close out the previous length and also be checked as a new first beat. The bench provokes this by issuing back-to-back NONSEQ beats, including a forbidden one right after a legal multi-beat burst. A behavioural reference model, compared on every clock, judges it: the completion strobe and length must belong to the old burst, and the error code must belong to the new beat. A second collision is a single SEQ beat with several faults at once, which must report only the highest-priority cause.

// File: rtl/ahb_burst_pkg.sv
package ahb_burst_pkg;

  typedef enum logic [1:0] {
    TR_IDLE   = 2'd0,
    TR_BUSY   = 2'd1,
    TR_NONSEQ = 2'd2,
    TR_SEQ    = 2'd3
  } trans_e;

  localparam logic [2:0] BT_SINGLE = 3'd0;
  localparam logic [2:0] BT_INCR   = 3'd1;
  localparam logic [2:0] SZ_WORD   = 3'd2;

  typedef enum logic [2:0] {
    ERR_NONE  = 3'd0,
    ERR_TYPE  = 3'd1,
    ERR_FIXED = 3'd2,
    ERR_LONG  = 3'd3,
    ERR_SIZE  = 3'd4,
    ERR_ADDR  = 3'd5
  } err_e;

endpackage

// File: rtl/ahb_burst_tracker.sv
module ahb_burst_tracker
  import ahb_burst_pkg::*;
#(
  parameter int AW    = 32,
  parameter int LEN_W = 6
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             hready,
  input  logic [1:0]       htrans,
  input  logic [2:0]       hburst,
  input  logic [2:0]       hsize,
  input  logic [AW-1:0]    haddr,
  output logic             active,
  output logic [LEN_W-1:0] count,
  output logic [AW-1:0]    prev_addr,
  output logic [2:0]       first_burst,
  output logic [2:0]       first_size,
  output logic             end_evt,
  output logic [LEN_W-1:0] end_len
);

  localparam logic [LEN_W-1:0] CNT_MAX = '1;
  localparam logic [LEN_W-1:0] CNT_ONE = LEN_W'(1);

  trans_e tr;
  assign tr = trans_e'(htrans);

  // a burst closes when an accepted IDLE or NONSEQ follows it
  assign end_evt = hready && active && (tr == TR_IDLE || tr == TR_NONSEQ);
  assign end_len = count;

  always_ff @(posedge clk) begin
    if (rst) begin
      active      <= 1'b0;
      count       <= '0;
      prev_addr   <= '0;
      first_burst <= '0;
      first_size  <= '0;
    end else if (hready) begin
      case (tr)
        TR_NONSEQ: begin
          active      <= 1'b1;
          count       <= CNT_ONE;
          prev_addr   <= haddr;
          first_burst <= hburst;
          first_size  <= hsize;
        end
        TR_SEQ: begin
          if (active) begin
            if (count != CNT_MAX) count <= count + CNT_ONE;
            prev_addr <= haddr;
          end
        end
        TR_IDLE: begin
          active <= 1'b0;
          count  <= '0;
        end
        default: ; // BUSY keeps the burst open and uncounted
      endcase
    end
  end

endmodule

// File: rtl/ahb_beat_classify.sv
module ahb_beat_classify
  import ahb_burst_pkg::*;
#(
  parameter int AW        = 32,
  parameter int LEN_W     = 6,
  parameter int MAX_BEATS = 14
) (
  input  logic [1:0]       htrans,
  input  logic [2:0]       hburst,
  input  logic [2:0]       hsize,
  input  logic [AW-1:0]    haddr,
  input  logic             hprot_data,
  input  logic             active,
  input  logic [LEN_W-1:0] count,
  input  logic [AW-1:0]    prev_addr,
  input  logic [2:0]       first_burst,
  input  logic [2:0]       first_size,
  output err_e             beat_err
);

  localparam logic [LEN_W-1:0] CAP = LEN_W'(MAX_BEATS);

  trans_e tr;
  logic   fixed_kind;
  logic   first_ok;
  logic   seq_type_bad;
  logic   seq_size_bad;
  logic   seq_addr_bad;

  assign tr           = trans_e'(htrans);
  assign fixed_kind   = (hburst > BT_INCR);
  assign first_ok     = hprot_data ? (hburst == BT_INCR) : (hburst == BT_SINGLE);
  assign seq_type_bad = (hburst != BT_INCR) || (active && hburst != first_burst);
  assign seq_size_bad = (hsize != SZ_WORD) || (active && first_size != SZ_WORD);
  assign seq_addr_bad = !active || (haddr != prev_addr + AW'(4));

  always_comb begin
    beat_err = ERR_NONE;
    if (tr == TR_NONSEQ) begin
      if (fixed_kind)     beat_err = ERR_FIXED;
      else if (!first_ok) beat_err = ERR_TYPE;
    end else if (tr == TR_SEQ) begin
      if (fixed_kind)         beat_err = ERR_FIXED;
      else if (seq_type_bad)  beat_err = ERR_TYPE;
      else if (seq_size_bad)  beat_err = ERR_SIZE;
      else if (seq_addr_bad)  beat_err = ERR_ADDR;
      else if (count >= CAP)  beat_err = ERR_LONG;
    end
  end

endmodule

// File: rtl/ahb_burst_stats.sv
module ahb_burst_stats #(
  parameter int LEN_W = 6
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             end_evt,
  input  logic [LEN_W-1:0] end_len,
  output logic [LEN_W-1:0] last_len,
  output logic [LEN_W-1:0] max_len,
  output logic             burst_done
);

  always_ff @(posedge clk) begin
    if (rst) begin
      last_len   <= '0;
      max_len    <= '0;
      burst_done <= 1'b0;
    end else begin
      burst_done <= end_evt;
      if (end_evt) begin
        last_len <= end_len;
        if (end_len > max_len) max_len <= end_len;
      end
    end
  end

endmodule

// File: rtl/ahb_burst_checker.sv
module ahb_burst_checker
  import ahb_burst_pkg::*;
#(
  parameter int AW      = 32,
  parameter int HAS_FPU = 0,
  parameter int LEN_W   = 6
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [1:0]       htrans,
  input  logic [2:0]       hburst,
  input  logic [2:0]       hsize,
  input  logic [AW-1:0]    haddr,
  input  logic             hprot_data,
  input  logic             hready,
  output logic             err_flag,
  output logic [2:0]       err_code,
  output logic [LEN_W-1:0] last_len,
  output logic [LEN_W-1:0] max_len,
  output logic             burst_done
);

  localparam int MAX_BEATS = (HAS_FPU != 0) ? 32 : 14;

  logic             active;
  logic [LEN_W-1:0] count;
  logic [AW-1:0]    prev_addr;
  logic [2:0]       first_burst;
  logic [2:0]       first_size;
  logic             end_evt;
  logic [LEN_W-1:0] end_len;
  err_e             beat_err;

  ahb_burst_tracker #(.AW(AW), .LEN_W(LEN_W)) u_track (
    .clk(clk), .rst(rst), .hready(hready), .htrans(htrans),
    .hburst(hburst), .hsize(hsize), .haddr(haddr),
    .active(active), .count(count), .prev_addr(prev_addr),
    .first_burst(first_burst), .first_size(first_size),
    .end_evt(end_evt), .end_len(end_len)
  );

  ahb_beat_classify #(.AW(AW), .LEN_W(LEN_W), .MAX_BEATS(MAX_BEATS)) u_class (
    .htrans(htrans), .hburst(hburst), .hsize(hsize), .haddr(haddr),
    .hprot_data(hprot_data), .active(active), .count(count),
    .prev_addr(prev_addr), .first_burst(first_burst),
    .first_size(first_size), .beat_err(beat_err)
  );

  ahb_burst_stats #(.LEN_W(LEN_W)) u_stats (
    .clk(clk), .rst(rst), .end_evt(end_evt), .end_len(end_len),
    .last_len(last_len), .max_len(max_len), .burst_done(burst_done)
  );

  // first violation wins and is held until reset
  always_ff @(posedge clk) begin
    if (rst) begin
      err_flag <= 1'b0;
      err_code <= ERR_NONE;
    end else if (hready && !err_flag && beat_err != ERR_NONE) begin
      err_flag <= 1'b1;
      err_code <= beat_err;
    end
  end

endmodule

// File: rtl/ahb_burst_checker_sva.sv
module ahb_burst_checker_sva #(
  parameter int LEN_W     = 6,
  parameter int MAX_BEATS = 14
) (
  input logic             clk,
  input logic             rst,
  input logic             hready,
  input logic             err_flag,
  input logic [2:0]       err_code,
  input logic [LEN_W-1:0] last_len,
  input logic [LEN_W-1:0] max_len,
  input logic             burst_done
);

  assert_flag_sticky_R11: assert property (@(posedge clk) disable iff (rst)
    err_flag |=> err_flag);

  assert_code_held_R11: assert property (@(posedge clk) disable iff (rst)
    err_flag |=> $stable(err_code));

  assert_code_clear_R11: assert property (@(posedge clk) disable iff (rst)
    !err_flag |-> err_code == 3'd0);

  assert_code_set_R11: assert property (@(posedge clk) disable iff (rst)
    err_flag |-> err_code != 3'd0);

  assert_max_monotonic_R10: assert property (@(posedge clk) disable iff (rst)
    !$past(rst) |-> max_len >= $past(max_len));

  assert_max_covers_last_R10: assert property (@(posedge clk) disable iff (rst)
    burst_done |-> max_len >= last_len);

  assert_stall_no_done_R9: assert property (@(posedge clk) disable iff (rst)
    !hready |=> !burst_done);

  assert_long_flagged_R7: assert property (@(posedge clk) disable iff (rst)
    (burst_done && last_len > LEN_W'(MAX_BEATS)) |-> err_flag);

endmodule

bind ahb_burst_checker ahb_burst_checker_sva #(
  .LEN_W(LEN_W), .MAX_BEATS(MAX_BEATS)
) u_sva (
  .clk(clk), .rst(rst), .hready(hready), .err_flag(err_flag),
  .err_code(err_code), .last_len(last_len), .max_len(max_len),
  .burst_done(burst_done)
);

// File: tb/test_ahb_burst_checker.sv
`timescale 1ns/1ps
module test_ahb_burst_checker;

  localparam int AW  = 32;
  localparam int MAX = 14;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic [1:0]    htrans = 2'd0;
  logic [2:0]    hburst = 3'd0;
  logic [2:0]    hsize  = 3'd0;
  logic [AW-1:0] haddr  = '0;
  logic          hprot_data = 1'b1;
  logic          hready = 1'b1;
  logic          err_flag, burst_done;
  logic [2:0]    err_code;
  logic [5:0]    last_len, max_len;

  always #4 clk = ~clk;

  ahb_burst_checker #(.AW(AW), .HAS_FPU(0)) i_ahb_burst_checker (
    .clk(clk), .rst(rst), .htrans(htrans), .hburst(hburst), .hsize(hsize),
    .haddr(haddr), .hprot_data(hprot_data), .hready(hready),
    .err_flag(err_flag), .err_code(err_code), .last_len(last_len),
    .max_len(max_len), .burst_done(burst_done)
  );

  int    n_chk = 0, n_fail = 0;
  string cur_req = "R1";

  // reference model state
  bit          m_act = 0;
  int          m_cnt = 0, m_fb = 0, m_fs = 0;
  logic [31:0] m_prev = 0;
  int          m_err = 0, m_code = 0, m_last = 0, m_max = 0, m_done = 0;

  task automatic chk(int act, int exp, string req, string what);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic model_edge(int tr, int bu, int sz, logic [31:0] ad, bit pr, bit rd);
    int e = 0;
    if (rst) begin
      m_act = 0; m_cnt = 0; m_prev = 0; m_fb = 0; m_fs = 0;
      m_err = 0; m_code = 0; m_last = 0; m_max = 0; m_done = 0;
      return;
    end
    m_done = 0;
    if (!rd) return;
    if (tr == 2) begin
      if (bu >= 2) e = 2;
      else if (pr ? bu != 1 : bu != 0) e = 1;
    end else if (tr == 3) begin
      if (bu >= 2) e = 2;
      else if (bu != 1 || (m_act && bu != m_fb)) e = 1;
      else if (sz != 2 || (m_act && m_fs != 2)) e = 4;
      else if (!m_act || ad != m_prev + 4) e = 5;
      else if (m_cnt >= MAX) e = 3;
    end
    if (m_err == 0 && e != 0) begin m_err = 1; m_code = e; end
    if (m_act && (tr == 0 || tr == 2)) begin
      m_done = 1; m_last = m_cnt;
      if (m_cnt > m_max) m_max = m_cnt;
    end
    case (tr)
      2: begin m_act = 1; m_cnt = 1; m_prev = ad; m_fb = bu; m_fs = sz; end
      3: if (m_act) begin if (m_cnt < 63) m_cnt++; m_prev = ad; end
      0: begin m_act = 0; m_cnt = 0; end
      default: ;
    endcase
  endtask

  task automatic step(int tr, int bu, int sz, logic [31:0] ad, bit pr, bit rd);
    htrans = 2'(tr); hburst = 3'(bu); hsize = 3'(sz);
    haddr = ad; hprot_data = pr; hready = rd;
    @(posedge clk);
    model_edge(tr, bu, sz, ad, pr, rd);
    @(negedge clk);
    chk(int'(err_flag), m_err, cur_req, "err_flag");
    chk(int'(err_code), m_code, cur_req, "err_code");
    chk(int'(burst_done), m_done, "R9", "burst_done");
    chk(int'(last_len), m_last, "R9", "last_len");
    chk(int'(max_len), m_max, "R10", "max_len");
  endtask

  task automatic idle(int n);
    for (int i = 0; i < n; i++) step(0, 0, 0, 0, 1, 1);
  endtask

  task automatic do_reset();
    rst = 1'b1;
    step(0, 0, 0, 0, 1, 1);
    step(0, 0, 0, 0, 1, 1);
    rst = 1'b0;
  endtask

  task automatic burst(int n, logic [31:0] a, int sz, bit pr, int bu);
    step(2, bu, sz, a, pr, 1);
    for (int i = 1; i < n; i++) step(3, bu, sz, a + 32'(4 * i), pr, 1);
  endtask

  initial begin
    #(200000 * 8);
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    @(negedge clk);
    cur_req = "R1";
    do_reset();
    idle(2);

    cur_req = "R5"; // byte, halfword, word singles, back to back
    step(2, 1, 0, 32'h101, 1, 1);
    step(2, 1, 1, 32'h202, 1, 1);
    step(2, 1, 2, 32'h304, 1, 1);
    idle(2);

    cur_req = "R3"; // legal fetch
    step(2, 0, 2, 32'h400, 0, 1);
    idle(1);

    cur_req = "R9"; // wait states and BUSY inside a 5-beat burst
    step(2, 1, 2, 32'h1000, 1, 1);
    step(3, 1, 2, 32'h1004, 1, 0);
    step(3, 1, 2, 32'h1004, 1, 1);
    step(1, 1, 2, 32'h1008, 1, 1);
    step(3, 1, 2, 32'h1008, 1, 1);
    step(3, 1, 2, 32'h100C, 1, 1);
    step(0, 0, 0, 0, 1, 0);
    step(3, 1, 2, 32'h1010, 1, 1);
    idle(2);

    cur_req = "R10"; // longest legal burst, then a shorter one
    burst(MAX, 32'h2000, 2, 1, 1);
    burst(3, 32'h3000, 2, 1, 1);
    idle(2);

    cur_req = "R4"; // forbidden fixed type right after a burst closes
    burst(4, 32'h3100, 2, 1, 1);
    step(2, 3, 2, 32'h3200, 1, 1);
    cur_req = "R11"; // later errors do not replace the first
    step(2, 0, 2, 32'h3300, 1, 1);
    step(3, 5, 0, 32'h3400, 1, 1);
    idle(2);

    cur_req = "R2"; do_reset();
    step(2, 0, 2, 32'h10, 1, 1); idle(1);
    cur_req = "R2"; do_reset();
    burst(2, 32'h40, 2, 1, 1);
    step(3, 0, 2, 32'h48, 1, 1); idle(1);

    cur_req = "R3"; do_reset();
    step(2, 1, 2, 32'h20, 0, 1); idle(1);

    cur_req = "R4"; do_reset();
    step(2, 7, 2, 32'h30, 0, 1); idle(1);

    cur_req = "R6"; do_reset();
    step(2, 1, 2, 32'h50, 1, 1);
    step(3, 1, 1, 32'h54, 1, 1); idle(1);
    cur_req = "R6"; do_reset();
    step(2, 1, 0, 32'h60, 1, 1);
    step(3, 1, 2, 32'h64, 1, 1); idle(1);

    cur_req = "R8"; do_reset();
    step(2, 1, 2, 32'h70, 1, 1);
    step(3, 1, 2, 32'h78, 1, 1); idle(1);
    cur_req = "R8"; do_reset();
    idle(1);
    step(3, 1, 2, 32'h80, 1, 1); idle(1);

    cur_req = "R7"; do_reset();
    burst(MAX + 1, 32'h900, 2, 1, 1);
    idle(2);

    cur_req = "R11"; do_reset(); // size and address both wrong: size wins
    step(2, 1, 2, 32'hA0, 1, 1);
    step(3, 1, 0, 32'hB0, 1, 1);
    idle(1);

    cur_req = "R1"; do_reset();
    idle(1);

    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

endmodule